// File: doc/BRIEF.md
# Pipelined FPU Issue Dispatcher

This block sits between the floating-point decoder and a pipelined FPU. Each cycle it decides whether the decoded floating-point operation may enter the FPU. Every operation carries a 2-bit latency class from the decoder. Three classes have a fixed latency and are pipelined, so independent operations can overlap and issue one per cycle at any configured depth. The fourth class covers variable-latency work such as divide and square root. It serializes: it waits until the pipeline has drained, and it blocks all later floating-point issue until the FPU returns a result carrying its tag.

The block keeps an in-flight table with one slot per pipeline stage. The slot position is the number of cycles left until writeback, and each slot stores the destination register. From this table the block finds read-after-write and write-after-write hazards, and it detects when two results would reach the single writeback port in the same cycle. A separate hazard output lets a non-floating-point instruction that reads or writes a floating-point register test itself against every outstanding destination, so integer work can continue while the FPU is busy.

Top module: `fpu_issue_ctrl`

## Requirements
- R1: After a synchronous active-low reset the in-flight table is empty, and `op_stall`, `fpu_busy` and `nf_hazard` are all low.
- R2: Class code 2'b00 has latency 1. Code 2'b01 has latency LAT_ADDMUL (default 2) and code 2'b10 has latency LAT_OTHER (default 3). Only code 2'b11 serializes. An operation issued in cycle t with latency L writes back in cycle t+L.
- R3: A run of independent fixed-latency operations of the same class issues one per cycle with no stall.
- R4: An operation with an enabled source equal to the destination of an outstanding operation is stalled. After a producer of latency L issues in cycle t, the dependent operation issues in cycle t+L+1 at the earliest.
- R5: An operation whose destination equals the destination of an outstanding operation is stalled until that operation's writeback cycle has passed.
- R6: A fixed-latency operation is refused if its writeback cycle would equal the writeback cycle of an operation already in flight.
- R7: A serializing operation (code 2'b11) issues only when no pipelined operation is in flight.
- R8: While a serializing operation is outstanding, every floating-point issue stalls. It is cleared in the cycle after `res_valid` is high with `res_tag` equal to its tag. A result with a different tag has no effect.
- R9: `op_stall` is high exactly when `op_valid` is high and `op_issue` is low.
- R10: `fpu_busy` is high whenever any operation, fixed or serializing, is outstanding.
- R11: `nf_hazard` is high when an enabled non-floating-point source or destination index equals the destination of any outstanding operation, including a serializing one.
- R12: A source whose bit in `op_src_en` is low never causes a stall. Bit 0 enables `op_src_a`, bit 1 enables `op_src_b` and bit 2 enables `op_src_c`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | A decoded floating-point operation is offered |
| op_lat_cls | input | 2 | Latency class code of the offered operation |
| op_tag | input | TAG_W | Tag the FPU will return for a serializing operation |
| op_dst | input | IDX_W | Destination register index |
| op_src_a | input | IDX_W | First source register index |
| op_src_b | input | IDX_W | Second source register index |
| op_src_c | input | IDX_W | Third source register index |
| op_src_en | input | 3 | Per-source enable, bit 0 = a, bit 1 = b, bit 2 = c |
| res_valid | input | 1 | FPU returns a result |
| res_tag | input | TAG_W | Tag of the returned result |
| nf_src_en | input | 1 | Non-floating-point instruction reads a floating-point register |
| nf_src | input | IDX_W | Index that instruction reads |
| nf_dst_en | input | 1 | Non-floating-point instruction writes a floating-point register |
| nf_dst | input | IDX_W | Index that instruction writes |
| op_issue | output | 1 | The offered operation is sent to the FPU this cycle |
| op_stall | output | 1 | The decoder must hold the offered operation |
| fpu_busy | output | 1 | At least one operation is outstanding |
| nf_hazard | output | 1 | The non-floating-point instruction conflicts with an outstanding destination |

## Verification
Two situations are hard to reach from the ports. The first is a writeback collision between operations that share no register. The stimulus issues a latency-3 operation and follows it at once with an independent latency-2 operation, so both results would land in the same cycle. The bench expects a single refusal and then an issue one cycle later. The second is a serializing operation that stays outstanding while a result with the wrong tag arrives. The bench first lets the operation wait behind a pipelined one, then sends a mismatched tag followed by the matching one. It checks that the waiting pipelined operation issues only in the cycle after the matching tag.

// File: rtl/fpu_issue_pkg.sv
// Shared definitions for the FPU issue dispatcher.
// Assumes the decoder uses these four latency class codes.
package fpu_issue_pkg;
    typedef enum logic [1:0] {
        CLS_SINGLE = 2'b00,
        CLS_ADDMUL = 2'b01,
        CLS_OTHER  = 2'b10,
        CLS_SERIAL = 2'b11
    } lat_cls_e;
endpackage

// File: rtl/fpu_inflight_table.sv
// In-flight table for fixed-latency FPU operations.
// Slot j holds the operation whose writeback is j cycles away (slot 0 is
// in writeback now). Every cycle the table shifts toward slot 0, and a newly
// issued operation of latency L enters slot L-1. The issuer must guarantee
// that the slot an operation shifts into is free.
module fpu_inflight_table #(
    parameter int DEPTH = 3,
    parameter int IDX_W = 5,
    parameter int POS_W = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ins_en,
    input  logic [POS_W-1:0]             ins_lat,
    input  logic [IDX_W-1:0]             ins_rd,
    output logic [DEPTH-1:0]             slot_vld,
    output logic [DEPTH-1:0][IDX_W-1:0]  slot_rd
);
    logic [DEPTH-1:0]            nxt_vld;
    logic [DEPTH-1:0][IDX_W-1:0] nxt_rd;

    // Next-state: shift every slot one step closer to writeback, then insert.
    always_comb begin
        nxt_vld = slot_vld >> 1;
        nxt_rd  = slot_rd >> IDX_W;
        if (ins_en) begin
            nxt_vld[ins_lat - POS_W'(1)] = 1'b1;
            nxt_rd[ins_lat - POS_W'(1)]  = ins_rd;
        end
    end

    // State register with synchronous reset clearing all slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_vld <= '0;
            slot_rd  <= '0;
        end else begin
            slot_vld <= nxt_vld;
            slot_rd  <= nxt_rd;
        end
    end

    AST_LAT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ins_en |-> (ins_lat >= POS_W'(1)) && (int'(ins_lat) <= DEPTH)); // R2
    AST_SLOT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_en && int'(ins_lat) < DEPTH) |-> !slot_vld[ins_lat]); // R6
endmodule

// File: rtl/fpu_serial_tracker.sv
// Tracks one outstanding serializing (variable-latency) FPU operation.
// The tag and destination are latched at issue, and the entry is released
// when the FPU returns a result with the same tag. Assumes at most one is
// outstanding, which the issuer guarantees.
module fpu_serial_tracker #(
    parameter int TAG_W = 3,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [TAG_W-1:0] start_tag,
    input  logic [IDX_W-1:0] start_rd,
    input  logic             res_valid,
    input  logic [TAG_W-1:0] res_tag,
    output logic             busy,
    output logic [IDX_W-1:0] hold_rd
);
    logic [TAG_W-1:0] hold_tag;
    logic             done;

    // Completion: a returned result that carries the held tag.
    always_comb done = busy && res_valid && (res_tag == hold_tag);

    // Busy flag, tag and destination registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            hold_tag <= '0;
            hold_rd  <= '0;
        end else if (start) begin
            busy     <= 1'b1;
            hold_tag <= start_tag;
            hold_rd  <= start_rd;
        end else if (done) begin
            busy     <= 1'b0;
        end
    end

    AST_ONE_SERIAL: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy); // R8
    AST_TAG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !start) |=> $stable(hold_tag)); // R8
endmodule

// File: rtl/fpu_dst_match.sv
// Compares one register index against every outstanding FPU destination,
// both the fixed-latency slots and the serializing entry.
module fpu_dst_match #(
    parameter int DEPTH = 3,
    parameter int IDX_W = 5
) (
    input  logic                         q_en,
    input  logic [IDX_W-1:0]             q_idx,
    input  logic [DEPTH-1:0]             slot_vld,
    input  logic [DEPTH-1:0][IDX_W-1:0]  slot_rd,
    input  logic                         ser_busy,
    input  logic [IDX_W-1:0]             ser_rd,
    output logic                         hit
);
    // OR together the per-slot matches with the serializing-entry match.
    always_comb begin
        hit = ser_busy && (ser_rd == q_idx);
        for (int j = 0; j < DEPTH; j++) begin
            hit = hit || (slot_vld[j] && (slot_rd[j] == q_idx));
        end
        hit = hit && q_en;
    end
endmodule

// File: rtl/fpu_issue_ctrl.sv
// FPU issue dispatcher (top).
// Grants issue to a decoded floating-point operation unless one of these
// holds: a serializing operation is outstanding, it has a RAW or WAW hazard
// with an outstanding destination, its fixed-latency result would collide on
// the single writeback port, or it is serializing while pipelined operations
// are still in flight. Assumes results of fixed classes appear exactly L
// cycles after issue.
module fpu_issue_ctrl #(
    parameter int IDX_W      = 5,
    parameter int TAG_W      = 3,
    parameter int LAT_ADDMUL = 2,
    parameter int LAT_OTHER  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [1:0]       op_lat_cls,
    input  logic [TAG_W-1:0] op_tag,
    input  logic [IDX_W-1:0] op_dst,
    input  logic [IDX_W-1:0] op_src_a,
    input  logic [IDX_W-1:0] op_src_b,
    input  logic [IDX_W-1:0] op_src_c,
    input  logic [2:0]       op_src_en,
    input  logic             res_valid,
    input  logic [TAG_W-1:0] res_tag,
    input  logic             nf_src_en,
    input  logic [IDX_W-1:0] nf_src,
    input  logic             nf_dst_en,
    input  logic [IDX_W-1:0] nf_dst,
    output logic             op_issue,
    output logic             op_stall,
    output logic             fpu_busy,
    output logic             nf_hazard
);
    import fpu_issue_pkg::*;

    localparam int MAX_LAT = (LAT_ADDMUL > LAT_OTHER) ? LAT_ADDMUL : LAT_OTHER;
    localparam int DEPTH   = (MAX_LAT > 1) ? MAX_LAT : 1;
    localparam int POS_W   = $clog2(DEPTH + 1);
    localparam int NQ      = 6;

    lat_cls_e                    cls;
    logic                        is_serial;
    logic [POS_W-1:0]            fix_lat;
    logic [DEPTH-1:0]            slot_vld;
    logic [DEPTH-1:0][IDX_W-1:0] slot_rd;
    logic [DEPTH:0]              occ_ext;
    logic                        ser_busy;
    logic [IDX_W-1:0]            ser_rd;
    logic [NQ-1:0]               q_en;
    logic [NQ-1:0][IDX_W-1:0]    q_idx;
    logic [NQ-1:0]               q_hit;
    logic                        raw_hit, waw_hit, wb_clash, any_inflight, blocked;

    // Map the class code to serialize or to a fixed latency.
    always_comb begin
        cls       = lat_cls_e'(op_lat_cls);
        is_serial = (cls == CLS_SERIAL);
        case (cls)
            CLS_ADDMUL: fix_lat = POS_W'(LAT_ADDMUL);
            CLS_OTHER:  fix_lat = POS_W'(LAT_OTHER);
            default:    fix_lat = POS_W'(1);
        endcase
    end

    // Gather the register indices that are compared against destinations.
    always_comb begin
        q_en  = {nf_dst_en, nf_src_en, 1'b1, op_src_en[2], op_src_en[1], op_src_en[0]};
        q_idx = {nf_dst, nf_src, op_dst, op_src_c, op_src_b, op_src_a};
    end

    // One comparator per queried index.
    for (genvar q = 0; q < NQ; q++) begin : g_match
        fpu_dst_match #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_match (
            .q_en     (q_en[q]),
            .q_idx    (q_idx[q]),
            .slot_vld (slot_vld),
            .slot_rd  (slot_rd),
            .ser_busy (ser_busy),
            .ser_rd   (ser_rd),
            .hit      (q_hit[q])
        );
    end

    // Issue decision: hazards, writeback port collision and serialization.
    always_comb begin
        raw_hit      = |q_hit[2:0];
        waw_hit      = q_hit[3];
        occ_ext      = {1'b0, slot_vld};
        wb_clash     = occ_ext[fix_lat];
        any_inflight = |slot_vld;
        if (ser_busy)       blocked = 1'b1;
        else if (is_serial) blocked = any_inflight;
        else                blocked = raw_hit || waw_hit || wb_clash;
        op_issue  = op_valid && !blocked;
        op_stall  = op_valid && blocked;
        fpu_busy  = any_inflight || ser_busy;
        nf_hazard = q_hit[4] || q_hit[5];
    end

    fpu_inflight_table #(.DEPTH(DEPTH), .IDX_W(IDX_W), .POS_W(POS_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .ins_en   (op_issue && !is_serial),
        .ins_lat  (fix_lat),
        .ins_rd   (op_dst),
        .slot_vld (slot_vld),
        .slot_rd  (slot_rd)
    );

    fpu_serial_tracker #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_serial (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (op_issue && is_serial),
        .start_tag (op_tag),
        .start_rd  (op_dst),
        .res_valid (res_valid),
        .res_tag   (res_tag),
        .busy      (ser_busy),
        .hold_rd   (ser_rd)
    );

    AST_SERIAL_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_issue && op_lat_cls == 2'b11) |-> !fpu_busy); // R7
    AST_NO_HAZARD_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        op_issue |-> !(q_hit[0] || q_hit[1] || q_hit[2] || q_hit[3])); // R4
    AST_BUSY_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        op_issue |=> fpu_busy); // R10
    AST_STALL_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        op_stall |-> (op_valid && !op_issue)); // R9
endmodule

// File: tb/fpu_issue_ctrl_test.sv
module fpu_issue_ctrl_test;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       op_valid;
    logic [1:0] op_lat_cls;
    logic [2:0] op_tag;
    logic [4:0] op_dst, op_src_a, op_src_b, op_src_c;
    logic [2:0] op_src_en;
    logic       res_valid;
    logic [2:0] res_tag;
    logic       nf_src_en, nf_dst_en;
    logic [4:0] nf_src, nf_dst;
    logic       op_issue, op_stall, fpu_busy, nf_hazard;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    fpu_issue_ctrl #(.IDX_W(5), .TAG_W(3), .LAT_ADDMUL(2), .LAT_OTHER(3)) uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_lat_cls(op_lat_cls),
        .op_tag(op_tag), .op_dst(op_dst), .op_src_a(op_src_a), .op_src_b(op_src_b),
        .op_src_c(op_src_c), .op_src_en(op_src_en), .res_valid(res_valid),
        .res_tag(res_tag), .nf_src_en(nf_src_en), .nf_src(nf_src),
        .nf_dst_en(nf_dst_en), .nf_dst(nf_dst), .op_issue(op_issue),
        .op_stall(op_stall), .fpu_busy(fpu_busy), .nf_hazard(nf_hazard)
    );

    task automatic chk(input bit act, input bit exp, input string rq, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0b expected=%0b at %0t", rq, what, act, exp, $time);
        end
    endtask

    // One cycle with an offered op; checks issue and stall mid-cycle.
    task automatic cyc_op(input bit v, input logic [1:0] cls, input logic [4:0] d,
                          input logic [4:0] a, input logic [4:0] b, input logic [4:0] c,
                          input logic [2:0] en, input logic [2:0] tg, input bit exp,
                          input string rq);
        op_valid = v; op_lat_cls = cls; op_dst = d; op_src_a = a;
        op_src_b = b; op_src_c = c; op_src_en = en; op_tag = tg;
        #(CLK_P/2);
        chk(op_issue, exp, rq, "op_issue");
        chk(op_stall, v && !exp, "R9", "op_stall");
        @(posedge clk); #1;
    endtask

    task automatic idle(input int n);
        op_valid = 1'b0;
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic t_reset;
        rst_n = 1'b0; op_valid = 1'b0; op_lat_cls = 2'b00; op_tag = '0;
        op_dst = '0; op_src_a = '0; op_src_b = '0; op_src_c = '0; op_src_en = '0;
        res_valid = 1'b0; res_tag = '0; nf_src_en = 1'b0; nf_src = '0;
        nf_dst_en = 1'b0; nf_dst = '0;
        repeat (3) @(posedge clk); #1;
        nf_src_en = 1'b1; nf_src = 5'd5; op_valid = 1'b1; op_lat_cls = 2'b01;
        #1;
        chk(fpu_busy, 1'b0, "R1", "fpu_busy after reset");
        chk(nf_hazard, 1'b0, "R1", "nf_hazard after reset");
        chk(op_stall, 1'b0, "R1", "op_stall after reset");
        op_valid = 1'b0; nf_src_en = 1'b0;
        rst_n = 1'b1;
        @(posedge clk); #1;
    endtask

    task automatic t_back_to_back;
        for (int i = 0; i < 10; i++)
            cyc_op(1, 2'b01, 5'(i + 1), 5'd20, 5'd21, 5'd22, 3'b111, 0, 1, "R3");
        chk(fpu_busy, 1'b1, "R10", "busy after run");
        idle(4);
        chk(fpu_busy, 1'b0, "R10", "idle after drain");
        for (int i = 0; i < 4; i++)
            cyc_op(1, 2'b10, 5'(i + 1), 5'd20, 5'd21, 5'd22, 3'b111, 0, 1, "R3");
        idle(5);
        for (int i = 0; i < 4; i++)
            cyc_op(1, 2'b00, 5'(i + 1), 5'd20, 5'd21, 5'd22, 3'b111, 0, 1, "R2");
        idle(3);
    endtask

    task automatic t_raw;
        cyc_op(1, 2'b01, 5'd5, 5'd20, 5'd21, 5'd22, 3'b111, 0, 1, "R4");
        nf_src_en = 1'b1; nf_src = 5'd5;
        #1;
        chk(nf_hazard, 1'b1, "R11", "nf source hits in-flight dst");
        cyc_op(1, 2'b01, 5'd6, 5'd5, 5'd21, 5'd22, 3'b111, 0, 0, "R4");
        cyc_op(1, 2'b01, 5'd6, 5'd5, 5'd21, 5'd22, 3'b111, 0, 0, "R4");
        cyc_op(1, 2'b01, 5'd6, 5'd5, 5'd21, 5'd22, 3'b111, 0, 1, "R4");
        nf_src = 5'd9;
        #1;
        chk(nf_hazard, 1'b0, "R11", "nf source on free register");
        nf_src_en = 1'b0;
        idle(4);
    endtask

    task automatic t_waw;
        cyc_op(1, 2'b10, 5'd7, 5'd20, 5'd21, 5'd22, 3'b111, 0, 1, "R5");
        cyc_op(1, 2'b00, 5'd7, 5'd0, 5'd0, 5'd0, 3'b000, 0, 0, "R5");
        cyc_op(1, 2'b00, 5'd7, 5'd0, 5'd0, 5'd0, 3'b000, 0, 0, "R5");
        cyc_op(1, 2'b00, 5'd7, 5'd0, 5'd0, 5'd0, 3'b000, 0, 0, "R5");
        cyc_op(1, 2'b00, 5'd7, 5'd0, 5'd0, 5'd0, 3'b000, 0, 1, "R5");
        idle(4);
    endtask

    task automatic t_src_disable;
        cyc_op(1, 2'b01, 5'd8, 5'd20, 5'd21, 5'd22, 3'b111, 0, 1, "R12");
        cyc_op(1, 2'b01, 5'd9, 5'd20, 5'd21, 5'd8, 3'b011, 0, 1, "R12");
        idle(4);
    endtask

    task automatic t_wb_clash;
        cyc_op(1, 2'b10, 5'd9, 5'd20, 5'd21, 5'd22, 3'b111, 0, 1, "R6");
        cyc_op(1, 2'b01, 5'd10, 5'd20, 5'd21, 5'd22, 3'b111, 0, 0, "R6");
        cyc_op(1, 2'b01, 5'd10, 5'd20, 5'd21, 5'd22, 3'b111, 0, 1, "R6");
        idle(4);
    endtask

    task automatic t_serial;
        cyc_op(1, 2'b10, 5'd11, 5'd20, 5'd21, 5'd22, 3'b111, 0, 1, "R7");
        for (int i = 0; i < 3; i++)
            cyc_op(1, 2'b11, 5'd12, 5'd20, 5'd21, 5'd0, 3'b011, 3'd3, 0, "R7");
        cyc_op(1, 2'b11, 5'd12, 5'd20, 5'd21, 5'd0, 3'b011, 3'd3, 1, "R7");
        nf_dst_en = 1'b1; nf_dst = 5'd12;
        #1;
        chk(nf_hazard, 1'b1, "R11", "nf dst hits serial dst");
        chk(fpu_busy, 1'b1, "R10", "busy with serial op");
        cyc_op(1, 2'b01, 5'd13, 5'd20, 5'd21, 5'd22, 3'b111, 0, 0, "R8");
        cyc_op(1, 2'b01, 5'd13, 5'd20, 5'd21, 5'd22, 3'b111, 0, 0, "R8");
        res_valid = 1'b1; res_tag = 3'd2;
        cyc_op(1, 2'b01, 5'd13, 5'd20, 5'd21, 5'd22, 3'b111, 0, 0, "R8");
        res_tag = 3'd3;
        cyc_op(1, 2'b01, 5'd13, 5'd20, 5'd21, 5'd22, 3'b111, 0, 0, "R8");
        res_valid = 1'b0;
        cyc_op(1, 2'b01, 5'd13, 5'd20, 5'd21, 5'd22, 3'b111, 0, 1, "R8");
        idle(3);
        chk(fpu_busy, 1'b0, "R10", "idle after serial");
        chk(nf_hazard, 1'b0, "R11", "nf dst clear after serial");
        nf_dst_en = 1'b0;
    endtask

    initial begin
        t_reset();
        t_back_to_back();
        t_raw();
        t_waw();
        t_src_disable();
        t_wb_clash();
        t_serial();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 100000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule